// File: doc/BRIEF.md
# Dual-Bank IRQ/FIQ Interrupt Controller

This block gathers forty level-sensitive interrupt sources into two 32-bit banks (bank 0 holds sources 0 to 31, bank 1 holds sources 32 to 39). Each source has three bits of state: a pending bit that tracks its input pin, an enable bit, and a steering bit. The steering bit picks which processor line the source drives: the fast line (`fiq_o`) or the normal line (`irq_o`). Software programs enables, steering, an idle-control bit and forty priority entries through a word-addressed register bus. It reads back the raw pending state and two filtered views, one per interrupt class.

A separate highest-priority encoder takes the priority entries and the per-source active vectors from this block. It returns its result on `hp_result`, and software reads that result through this block's register space. While the core reports that it is halted, the block raises `wake_o` for any pending source that is enabled. Once software sets the idle mask, any pending source wakes the core, whether enabled or not.

Top module: `irq_steer_ctrl`

## Requirements
- R1: Source k lives in bank 1 when k >= 32 and in bank 0 otherwise, at bit position k mod 32. Bank-1 registers read bits 31:8 as zero, and writes to those bits are dropped.
- R2: A source's pending bit is the input level sampled at the previous clock edge. It is high while the input is high and low again once the input falls. There is no latching and no software clear.
- R3: `fiq_o` is high when any source is pending, enabled and steered fast (steer = 1). `irq_o` is high when any source is pending, enabled and steered normal (steer = 0). Each output is registered one cycle behind the pending bits.
- R4: The register map uses byte address words. For bank 0, the words are: normal-pending view 0x00, enable 0x04, steering 0x08, fast-pending view 0x0C, raw pending 0x10. For bank 1, the same five registers sit at 0x9C, 0xA0, 0xA4, 0xA8 and 0xAC. Idle control is at 0x14 and the encoder result at 0x18. Priority entries 0 to 31 are at 0x1C + 4n, and entries 32 to 39 are at 0xB0 + 4(n-32).
- R5: The normal-pending view reads pending & enable & ~steer. The fast-pending view reads pending & enable & steer. Raw pending reads pending with no filter.
- R6: Writing idle control with bit 0 = 1 clears the idle mask. Writing bit 0 = 0 sets the mask. A read returns 1 when the mask is clear and 0 when it is set.
- R7: `wake_o` is registered. It is high one cycle after a cycle in which `core_halted` is high and at least one source is pending with (enable or idle mask) set. Otherwise it is low.
- R8: A priority entry stores only bits 31 and 5:0 of the write data, so a read returns the written value & 0x8000003F. The entries also appear on `prio_flat` as 7-bit fields {bit31, bits 5:0}, with entry n at bits 7n+6:7n.
- R9: The following reads return 0: an undefined word, or an address with bits 1:0 nonzero. Writes to an undefined word, a misaligned address or a read-only register (views, raw pending, encoder result) change no state.
- R10: Reset (synchronous, active high) clears pending, enable, steering, the idle mask, every priority entry, the outputs and `rdata`.
- R11: A read with `rd_en` high at a clock edge places its data on `rdata` at that edge. `rdata` then holds until the next read.
- R12: Word 0x18 reads the `hp_result` input. `fiq_active` and `irq_active` give the per-source pending & enable & steer and pending & enable & ~steer vectors to the encoder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | 40 | Interrupt source levels |
| core_halted | input | 1 | Core is halted and may be woken |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| hp_result | input | 32 | Result from the external priority encoder |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |
| wake_o | output | 1 | Wake request to a halted core |
| fiq_active | output | 40 | Pending, enabled, fast-steered sources |
| irq_active | output | 40 | Pending, enabled, normal-steered sources |
| prio_flat | output | 280 | Priority entries, 7 bits each |

## Verification
The bench targets four corner cases, each with the symptom a faulty design would show:
- **Bank boundary.** It uses sources 31, 32 and 39. A design that maps banks wrongly shows the bit in the wrong view, or drops source 39.
- **Mixed steering.** Some vectors have one fast and one normal source active at once. A design that lets steering override enable, or that merges the two classes, drives only one of the lines or the wrong one.
- **Idle rule.** The idle mask is toggled while a masked source is pending and the core is halted. A design with the mask polarity inverted wakes the core when it should not, or misses the wake.
- **Register edges.** The bench checks the read-only registers, the misaligned and undefined addresses, and a priority write with all bits set. These expose a register that takes stray writes or keeps reserved bits.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // word indices (byte address / 4)
  localparam int WORD_IDLE    = 5;
  localparam int WORD_HP      = 6;
  localparam int WORD_PRIO_LO = 7;
  localparam int BANK1_BASE   = 39;
  localparam int WORD_PRIO_HI = 44;
  localparam int BANK_WORDS   = 5;
  localparam int ID_W         = 6;
  localparam int PRIO_W       = ID_W + 1;

  // order inside each bank group of five words
  typedef enum logic [2:0] {
    VIEW_IRQ   = 3'd0,
    VIEW_MASK  = 3'd1,
    VIEW_STEER = 3'd2,
    VIEW_FIQ   = 3'd3,
    VIEW_RAW   = 3'd4
  } bank_reg_e;
endpackage

// File: rtl/irqc_route.sv
module irqc_route #(
  parameter int NUM_SRC = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic [NUM_SRC-1:0] en,
  input  logic [NUM_SRC-1:0] steer,
  input  logic               idle_all,
  input  logic               core_halted,
  output logic [NUM_SRC-1:0] pend,
  output logic [NUM_SRC-1:0] fiq_act,
  output logic [NUM_SRC-1:0] irq_act,
  output logic               fiq_o,
  output logic               irq_o,
  output logic               wake_o
);
  logic [NUM_SRC-1:0] wake_src;
  logic               seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      seen <= 1'b0;
    end else begin
      pend <= src_lvl;
      seen <= 1'b1;
    end
  end

  always_comb begin
    fiq_act  = pend & en & steer;
    irq_act  = pend & en & ~steer;
    wake_src = pend & (en | {NUM_SRC{idle_all}});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fiq_o  <= 1'b0;
      irq_o  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      fiq_o  <= |fiq_act;
      irq_o  <= |irq_act;
      wake_o <= core_halted & (|wake_src);
    end
  end

  // R2: pending is the level seen at the previous edge
  p_level_follow_r2: assert property (@(posedge clk) disable iff (rst)
    seen |-> pend == $past(src_lvl)) else $error("pending not tracking level");

  // R3: no request without an enabled pending source
  p_gate_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(|(pend & en)) |-> (!fiq_o && !irq_o)) else $error("ungated request");

  // R3: fast line only for fast-steered sources
  p_fiq_steer_r3: assert property (@(posedge clk) disable iff (rst)
    fiq_o |-> $past(|(pend & steer))) else $error("fiq without fast source");

  // R7: wake only follows a halted cycle
  p_wake_halt_r7: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> $past(core_halted)) else $error("wake while running");
endmodule

// File: rtl/irqc_prio_store.sv
module irqc_prio_store #(
  parameter int NUM_SRC = 40,
  parameter int PW      = 7,
  localparam int IDXW   = $clog2(NUM_SRC)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [IDXW-1:0]       widx,
  input  logic [PW-1:0]         wval,
  input  logic [IDXW-1:0]       ridx,
  output logic [PW-1:0]         rval,
  output logic [NUM_SRC*PW-1:0] flat
);
  logic [PW-1:0]   ent [NUM_SRC];
  logic            last_we;
  logic [IDXW-1:0] last_idx;
  logic [PW-1:0]   last_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SRC; i++) ent[i] <= '0;
    end else if (we) begin
      ent[widx] <= wval;
    end
  end

  assign rval = ent[ridx];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flat
    assign flat[g*PW +: PW] = ent[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_we  <= 1'b0;
      last_idx <= '0;
      last_val <= '0;
    end else begin
      last_we  <= we;
      last_idx <= widx;
      last_val <= wval;
    end
  end

  // R8: a written entry holds exactly the value presented
  p_prio_store_r8: assert property (@(posedge clk) disable iff (rst)
    last_we |-> ent[last_idx] == last_val) else $error("priority entry lost");
endmodule

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int AW      = 12,
  parameter int DW      = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SRC-1:0]        src_lvl,
  input  logic                      core_halted,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [AW-1:0]             addr,
  input  logic [DW-1:0]             wdata,
  output logic [DW-1:0]             rdata,
  input  logic [DW-1:0]             hp_result,
  output logic                      fiq_o,
  output logic                      irq_o,
  output logic                      wake_o,
  output logic [NUM_SRC-1:0]        fiq_active,
  output logic [NUM_SRC-1:0]        irq_active,
  output logic [NUM_SRC*PRIO_W-1:0] prio_flat
);
  localparam int IDXW   = $clog2(NUM_SRC);
  localparam int HI_CNT = NUM_SRC - 32;

  logic [NUM_SRC-1:0] en_q, steer_q, pend;
  logic               idle_all;
  logic               bank_hit, bank_sel, idle_hit, hp_hit, prio_hit, any_hit;
  bank_reg_e          breg;
  logic [IDXW-1:0]    prio_idx;
  logic [PRIO_W-1:0]  prio_rval;
  logic [DW-1:0]      rd_val;

  function automatic logic [DW-1:0] bank_slice(input logic [NUM_SRC-1:0] v,
                                               input logic b);
    logic [DW-1:0] s;
    s = '0;
    for (int k = 0; k < NUM_SRC; k++)
      if ((k / 32) == int'(b)) s[k % 32] = v[k];
    return s;
  endfunction

  // address decode
  always_comb begin
    int w;
    w        = int'(addr[AW-1:2]);
    bank_hit = 1'b0;
    bank_sel = 1'b0;
    breg     = VIEW_IRQ;
    idle_hit = 1'b0;
    hp_hit   = 1'b0;
    prio_hit = 1'b0;
    prio_idx = '0;
    if (addr[1:0] == 2'b00) begin
      if (w < BANK_WORDS) begin
        bank_hit = 1'b1;
        breg     = bank_reg_e'(3'(w));
      end else if (w >= BANK1_BASE && w < BANK1_BASE + BANK_WORDS) begin
        bank_hit = 1'b1;
        bank_sel = 1'b1;
        breg     = bank_reg_e'(3'(w - BANK1_BASE));
      end else if (w == WORD_IDLE) begin
        idle_hit = 1'b1;
      end else if (w == WORD_HP) begin
        hp_hit = 1'b1;
      end else if (w >= WORD_PRIO_LO && w < WORD_PRIO_LO + 32) begin
        prio_hit = 1'b1;
        prio_idx = IDXW'(w - WORD_PRIO_LO);
      end else if (w >= WORD_PRIO_HI && w < WORD_PRIO_HI + HI_CNT) begin
        prio_hit = 1'b1;
        prio_idx = IDXW'(32 + w - WORD_PRIO_HI);
      end
    end
    any_hit = bank_hit | idle_hit | hp_hit | prio_hit;
  end

  // writable state
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      steer_q  <= '0;
      idle_all <= 1'b0;
    end else if (wr_en) begin
      if (bank_hit && breg == VIEW_MASK) begin
        for (int k = 0; k < NUM_SRC; k++)
          if ((k / 32) == int'(bank_sel)) en_q[k] <= wdata[k % 32];
      end
      if (bank_hit && breg == VIEW_STEER) begin
        for (int k = 0; k < NUM_SRC; k++)
          if ((k / 32) == int'(bank_sel)) steer_q[k] <= wdata[k % 32];
      end
      if (idle_hit) idle_all <= ~wdata[0];
    end
  end

  irqc_prio_store #(.NUM_SRC(NUM_SRC), .PW(PRIO_W)) u_prio (
    .clk  (clk),
    .rst  (rst),
    .we   (wr_en & prio_hit),
    .widx (prio_idx),
    .wval ({wdata[DW-1], wdata[ID_W-1:0]}),
    .ridx (prio_idx),
    .rval (prio_rval),
    .flat (prio_flat)
  );

  irqc_route #(.NUM_SRC(NUM_SRC)) u_route (
    .clk         (clk),
    .rst         (rst),
    .src_lvl     (src_lvl),
    .en          (en_q),
    .steer       (steer_q),
    .idle_all    (idle_all),
    .core_halted (core_halted),
    .pend        (pend),
    .fiq_act     (fiq_active),
    .irq_act     (irq_active),
    .fiq_o       (fiq_o),
    .irq_o       (irq_o),
    .wake_o      (wake_o)
  );

  // read mux
  always_comb begin
    rd_val = '0;
    if (bank_hit) begin
      case (breg)
        VIEW_IRQ:   rd_val = bank_slice(irq_active, bank_sel);
        VIEW_MASK:  rd_val = bank_slice(en_q, bank_sel);
        VIEW_STEER: rd_val = bank_slice(steer_q, bank_sel);
        VIEW_FIQ:   rd_val = bank_slice(fiq_active, bank_sel);
        VIEW_RAW:   rd_val = bank_slice(pend, bank_sel);
        default:    rd_val = '0;
      endcase
    end else if (idle_hit) begin
      rd_val = {{(DW-1){1'b0}}, ~idle_all};
    end else if (hp_hit) begin
      rd_val = hp_result;
    end else if (prio_hit) begin
      rd_val = {prio_rval[ID_W], {(DW-1-ID_W){1'b0}}, prio_rval[ID_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end

  // R9: undefined or misaligned reads return zero
  p_undef_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_en) && !$past(any_hit)) |-> rdata == '0)
    else $error("undefined read not zero");

  // R6: idle mask takes the inverse of the written bit
  p_idle_write_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en && idle_hit)) |-> idle_all == !$past(wdata[0]))
    else $error("idle mask write wrong");

  // R10: reset leaves enables and steering cleared
  p_reset_clear_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (en_q == '0 && steer_q == '0 && !idle_all))
    else $error("state not cleared by reset");

  // R11: rdata moves only on a read
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rd_en)) |-> $stable(rdata))
    else $error("rdata changed without read");
endmodule

// File: tb/irq_steer_ctrl_test.sv
`timescale 1ns/1ps
module irq_steer_ctrl_test;
  logic         clk = 1'b0;
  logic         rst;
  logic [39:0]  src_lvl;
  logic         core_halted;
  logic         wr_en, rd_en;
  logic [11:0]  addr;
  logic [31:0]  wdata, rdata, hp_result;
  logic         fiq_o, irq_o, wake_o;
  logic [39:0]  fiq_active, irq_active;
  logic [279:0] prio_flat;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;

  always #5 clk = ~clk;

  irq_steer_ctrl uut (
    .clk(clk), .rst(rst), .src_lvl(src_lvl), .core_halted(core_halted),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .hp_result(hp_result), .fiq_o(fiq_o), .irq_o(irq_o), .wake_o(wake_o),
    .fiq_active(fiq_active), .irq_active(irq_active), .prio_flat(prio_flat)
  );

  // {src, enable, steer, expected fiq, expected irq}
  localparam logic [121:0] VECS [6] = '{
    {40'h00_0000_0000, 40'hFF_FFFF_FFFF, 40'h00_0000_0000, 1'b0, 1'b0},
    {40'h00_0000_0001, 40'h00_0000_0001, 40'h00_0000_0000, 1'b0, 1'b1},
    {40'h80_0000_0000, 40'h80_0000_0000, 40'h80_0000_0000, 1'b1, 1'b0},
    {40'h02_0000_0020, 40'h02_0000_0000, 40'h00_0000_0020, 1'b0, 1'b1},
    {40'h01_8000_0000, 40'h01_8000_0000, 40'h00_8000_0000, 1'b1, 1'b1},
    {40'hFF_FFFF_FFFF, 40'h00_0000_0000, 40'hFF_FFFF_FFFF, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst = 1'b1; src_lvl = '0; core_halted = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    addr = '0; wdata = '0; hp_result = 32'hDEAD_BEEF;
    tick(3);
    rst = 1'b0;
    tick(1);

    // reset state
    chk("R10 fiq after reset", 64'(fiq_o), 64'h0);
    chk("R10 irq after reset", 64'(irq_o), 64'h0);
    bus_read(12'h004, d); chk("R10 enable0 reset", 64'(d), 64'h0);
    bus_read(12'h0A4, d); chk("R10 steer1 reset", 64'(d), 64'h0);
    bus_read(12'h014, d); chk("R10 R6 idle read after reset", 64'(d), 64'h1);
    bus_read(12'h01C, d); chk("R10 prio0 reset", 64'(d), 64'h0);

    // vector table
    foreach (VECS[i]) begin
      logic [39:0] s, e, t, fv, iv;
      s = VECS[i][121:82]; e = VECS[i][81:42]; t = VECS[i][41:2];
      fv = s & e & t; iv = s & e & ~t;
      bus_write(12'h004, e[31:0]);
      bus_write(12'h0A0, {24'h0, e[39:32]});
      bus_write(12'h008, t[31:0]);
      bus_write(12'h0A4, {24'h0, t[39:32]});
      src_lvl = s;
      tick(3);
      chk($sformatf("R3 fiq vec%0d", i), 64'(fiq_o), 64'(VECS[i][1]));
      chk($sformatf("R3 irq vec%0d", i), 64'(irq_o), 64'(VECS[i][0]));
      chk($sformatf("R12 fiq_active vec%0d", i), 64'(fiq_active), 64'(fv));
      chk($sformatf("R12 irq_active vec%0d", i), 64'(irq_active), 64'(iv));
      bus_read(12'h000, d); chk($sformatf("R5 irq view0 vec%0d", i), 64'(d), 64'(iv[31:0]));
      bus_read(12'h09C, d); chk($sformatf("R5 irq view1 vec%0d", i), 64'(d), 64'(iv[39:32]));
      bus_read(12'h00C, d); chk($sformatf("R5 fiq view0 vec%0d", i), 64'(d), 64'(fv[31:0]));
      bus_read(12'h0A8, d); chk($sformatf("R5 fiq view1 vec%0d", i), 64'(d), 64'(fv[39:32]));
      bus_read(12'h010, d); chk($sformatf("R1 raw0 vec%0d", i), 64'(d), 64'(s[31:0]));
      bus_read(12'h0AC, d); chk($sformatf("R1 raw1 vec%0d", i), 64'(d), 64'(s[39:32]));
    end

    // R1: bank-1 upper bits do not exist
    bus_write(12'h0A0, 32'hFFFF_FFFF);
    bus_read(12'h0A0, d); chk("R1 enable1 width", 64'(d), 64'hFF);

    // R2 / R3 latency and no latching
    src_lvl = '0;
    bus_write(12'h004, 32'h1);
    bus_write(12'h0A0, 32'h0);
    bus_write(12'h008, 32'h0);
    tick(3);
    src_lvl = 40'h1;
    tick(1); chk("R3 irq not yet one edge", 64'(irq_o), 64'h0);
    tick(1); chk("R3 irq after two edges", 64'(irq_o), 64'h1);
    src_lvl = '0;
    tick(2); chk("R2 irq drops with level", 64'(irq_o), 64'h0);
    bus_read(12'h010, d); chk("R2 raw pending cleared", 64'(d), 64'h0);

    // R9: read-only, undefined and misaligned
    src_lvl = 40'h80;
    bus_write(12'h010, 32'h0);
    bus_write(12'h00C, 32'hFFFF_FFFF);
    bus_write(12'h300, 32'hFFFF_FFFF);
    bus_write(12'h009, 32'hFFFF_FFFF);
    bus_read(12'h010, d); chk("R9 raw pending not writable", 64'(d), 64'h80);
    bus_read(12'h004, d); chk("R9 enable0 untouched", 64'(d), 64'h1);
    bus_read(12'h008, d); chk("R9 steer0 untouched", 64'(d), 64'h0);
    bus_read(12'h300, d); chk("R9 undefined read", 64'(d), 64'h0);
    bus_read(12'h0D0, d); chk("R9 past last entry", 64'(d), 64'h0);
    bus_read(12'h005, d); chk("R9 misaligned read", 64'(d), 64'h0);

    // R8 priority entries
    bus_write(12'h01C, 32'hFFFF_FFFF);
    bus_read(12'h01C, d); chk("R8 prio0 mask", 64'(d), 64'h8000_003F);
    bus_write(12'h0CC, 32'h1234_5685);
    bus_read(12'h0CC, d); chk("R8 prio39 mask", 64'(d), 64'h5);
    chk("R8 prio39 flat", 64'(prio_flat[273 +: 7]), 64'h05);
    chk("R8 prio0 flat", 64'(prio_flat[6:0]), 64'h7F);
    bus_write(12'h0B4, 32'h8000_0021);
    bus_read(12'h0B4, d); chk("R4 prio33 address", 64'(d), 64'h8000_0021);

    // R12 encoder result
    bus_read(12'h018, d); chk("R12 hp result read", 64'(d), 64'hDEAD_BEEF);
    bus_write(12'h018, 32'h0);
    bus_read(12'h018, d); chk("R9 hp not writable", 64'(d), 64'hDEAD_BEEF);

    // R6 / R7 idle wake
    bus_write(12'h004, 32'h0);
    src_lvl = 40'h8;
    core_halted = 1'b1;
    tick(3); chk("R7 masked source no wake", 64'(wake_o), 64'h0);
    bus_write(12'h014, 32'h0);
    tick(2); chk("R7 idle mask set wakes", 64'(wake_o), 64'h1);
    bus_read(12'h014, d); chk("R6 idle read set", 64'(d), 64'h0);
    bus_write(12'h014, 32'h1);
    tick(2); chk("R7 idle mask cleared no wake", 64'(wake_o), 64'h0);
    bus_read(12'h014, d); chk("R6 idle read clear", 64'(d), 64'h1);
    bus_write(12'h004, 32'h8);
    tick(2); chk("R7 enabled source wakes", 64'(wake_o), 64'h1);
    core_halted = 1'b0;
    tick(2); chk("R7 no wake while running", 64'(wake_o), 64'h0);
    bus_write(12'h014, 32'h0);

    // R10 reset mid-run
    src_lvl = '0;
    @(negedge clk); rst = 1'b1;
    tick(2); rst = 1'b0;
    tick(1);
    bus_read(12'h004, d); chk("R10 enable0 after rerun reset", 64'(d), 64'h0);
    bus_read(12'h01C, d); chk("R10 prio0 after rerun reset", 64'(d), 64'h0);
    bus_read(12'h014, d); chk("R10 idle after rerun reset", 64'(d), 64'h1);
    chk("R10 wake after rerun reset", 64'(wake_o), 64'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule